// File: doc/BRIEF.md
# Shared Fixed-Latency Word Memory

A small word-addressed store that several pipeline clients share for writes. It holds `LINES` lines of four words each. Three clients (the memory stage, the instruction fetch stage and the first-level cache) can each present a write with its own address and data. The memory serves one client at a time and holds that client until its access is complete. Each cycle, every client gets a status bit: high means OK (the write commits on this edge), low means WAIT.

When no client holds the memory, the first one to ask becomes the holder, and that cycle already counts toward the configured latency `DELAY`. A holder that keeps asking therefore sees `DELAY` cycles of WAIT and then one cycle of OK. The memory goes free on the edge that follows.

A side-door write port commits at once, whatever the arbitration is doing. A debug port returns all four words of any line without affecting arbitration. Both ports are meant for loaders and test equipment.

Top module: `shared_wmem`

## Requirements
- R1: After a synchronous active-high reset, every word reads zero on the debug port, no client holds the memory, and the side-door status is low while the side-door write enable is low.
- R2: Word address `a` selects line `a >> 2` and word `a & 3`. The debug port places word k of the selected line at bits `[32k+31:32k]`.
- R3: A client that holds the memory keeps it until its OK cycle. Any other client gets WAIT during that time, and the memory does not change for it. A status bit is never high unless its request bit is high.
- R4: When the memory is free and several clients ask in the same cycle, the lowest request index wins. Index 0 is the memory stage, index 1 the fetch stage and index 2 the cache.
- R5: A holder that asks in every cycle sees exactly `DELAY` cycles of WAIT, then OK in the next cycle. Its write is visible on the debug port after that cycle's edge.
- R6: The memory goes free on the edge that ends the OK cycle. A different client that asks during the OK cycle gets WAIT. If it keeps asking, it takes the memory in the next cycle and waits `DELAY` cycles of its own.
- R7: With `DELAY = 0`, a client that asks while the memory is free gets OK in that same cycle. A second client that asks in that cycle gets WAIT and gets OK in the next cycle.
- R8: A side-door write gets OK in the same cycle (side-door status high) and commits on the edge. It does not change which client holds the memory or when that client gets OK.
- R9: The debug port is combinational from its line index. Changing the index does not change any status timing.
- R10: If the side door and a client's completing write hit the same word on the same edge, the side-door data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | NREQ | Write request per client; index 0 = memory stage, 1 = fetch, 2 = cache |
| addr_i | input | NREQ*AW | Word address per client, client i at bits [AW*i +: AW] |
| data_i | input | NREQ*WORD_W | Write data per client, client i at bits [WORD_W*i +: WORD_W] |
| ok_o | output | NREQ | Per-client status: 1 = OK, 0 = WAIT |
| sd_we_i | input | 1 | Side-door write enable |
| sd_addr_i | input | AW | Side-door word address |
| sd_data_i | input | WORD_W | Side-door write data |
| sd_ok_o | output | 1 | Side-door status, high when the side-door write is accepted |
| dbg_line_i | input | LW | Debug line index |
| dbg_words_o | output | 4*WORD_W | The four words of the selected line |

## Verification
The assertions assume that a client keeps its request stable until it sees OK, and that addresses stay inside the configured line count. When either of these is broken, the held-owner and status checks are not meaningful. The directed stimulus holds each request and its address and data fixed from the first cycle through the OK cycle, and drops the request only after OK. All addresses fall within the four default lines.

// File: rtl/shared_wmem.sv
module shared_wmem #(
  parameter int LINES  = 4,
  parameter int WORD_W = 32,
  parameter int NREQ   = 3,
  parameter int DELAY  = 3,
  localparam int LW = $clog2(LINES),
  localparam int AW = LW + 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NREQ-1:0]        req_i,
  input  logic [NREQ*AW-1:0]     addr_i,
  input  logic [NREQ*WORD_W-1:0] data_i,
  output logic [NREQ-1:0]        ok_o,
  input  logic                   sd_we_i,
  input  logic [AW-1:0]          sd_addr_i,
  input  logic [WORD_W-1:0]      sd_data_i,
  output logic                   sd_ok_o,
  input  logic [LW-1:0]          dbg_line_i,
  output logic [4*WORD_W-1:0]    dbg_words_o
);
  localparam int CW = $clog2(DELAY + 2);
  localparam int IW = (NREQ > 1) ? $clog2(NREQ) : 1;
  localparam int NWORDS = LINES * 4;

  logic [WORD_W-1:0] mem [NWORDS];
  logic              own_v;
  logic [IW-1:0]     own_id;
  logic [CW-1:0]     cnt;

  logic              pick_v;
  logic [IW-1:0]     pick_id;
  logic              cur_v;
  logic [IW-1:0]     cur_id;
  logic              done;
  logic [AW-1:0]     gnt_addr;
  logic [WORD_W-1:0] gnt_data;

  always_comb begin
    pick_v  = 1'b0;
    pick_id = '0;
    for (int i = NREQ - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        pick_v  = 1'b1;
        pick_id = IW'(i);
      end
    end
  end

  assign cur_v    = own_v | pick_v;
  assign cur_id   = own_v ? own_id : pick_id;
  assign done     = cur_v && (cnt == '0);
  assign gnt_addr = addr_i[cur_id*AW +: AW];
  assign gnt_data = data_i[cur_id*WORD_W +: WORD_W];
  assign sd_ok_o  = sd_we_i;

  always_comb begin
    ok_o = '0;
    if (done && req_i[cur_id]) ok_o[cur_id] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      own_v  <= 1'b0;
      own_id <= '0;
      cnt    <= CW'(DELAY);
      for (int w = 0; w < NWORDS; w++) mem[w] <= '0;
    end else begin
      if (cur_v) begin
        if (cnt == '0) begin
          own_v <= 1'b0;
          cnt   <= CW'(DELAY);
        end else begin
          own_v  <= 1'b1;
          own_id <= cur_id;
          cnt    <= cnt - 1'b1;
        end
      end
      if (|ok_o) mem[gnt_addr] <= gnt_data;
      if (sd_we_i) mem[sd_addr_i] <= sd_data_i;
    end
  end

  for (genvar k = 0; k < 4; k++) begin : g_dbg
    assign dbg_words_o[k*WORD_W +: WORD_W] = mem[{dbg_line_i, 2'(k)}];
  end
endmodule

module shared_wmem_chk #(
  parameter int NREQ  = 3,
  parameter int DELAY = 3,
  parameter int IW    = 2,
  parameter int CW    = 3
) (
  input logic            clk,
  input logic            rst,
  input logic [NREQ-1:0] req_i,
  input logic [NREQ-1:0] ok_o,
  input logic            own_v,
  input logic [IW-1:0]   own_id,
  input logic [CW-1:0]   cnt
);
  a_r3_ok_needs_req: assert property (@(posedge clk) disable iff (rst)
    (ok_o & ~req_i) == '0);

  a_r4_single_ok: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ok_o));

  a_r3_owner_held: assert property (@(posedge clk) disable iff (rst)
    (own_v && cnt != '0) |=> (own_v && own_id == $past(own_id)));

  a_r5_count_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DELAY));

  a_r6_release_gap: assert property (@(posedge clk) disable iff (rst)
    ((DELAY > 0) && (|ok_o)) |=> !(|ok_o));
endmodule

bind shared_wmem shared_wmem_chk #(.NREQ(NREQ), .DELAY(DELAY), .IW(IW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .req_i(req_i), .ok_o(ok_o),
  .own_v(own_v), .own_id(own_id), .cnt(cnt)
);

// File: tb/sim_shared_wmem.sv
module sim_shared_wmem;
  localparam int CLK_PERIOD = 10;
  localparam int D0 = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [2:0]   req = '0, req_z = '0;
  logic [11:0]  addr = '0, addr_z = '0;
  logic [95:0]  data = '0, data_z = '0;
  logic [2:0]   ok, ok_z;
  logic         sd_we = 1'b0, sd_ok, sd_ok_z;
  logic [3:0]   sd_addr = '0;
  logic [31:0]  sd_data = '0;
  logic [1:0]   dbg_line = '0, dbg_line_z = '0;
  logic [127:0] dbg, dbg_z;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  shared_wmem #(.LINES(4), .WORD_W(32), .NREQ(3), .DELAY(D0)) u0 (
    .clk(clk), .rst(rst), .req_i(req), .addr_i(addr), .data_i(data), .ok_o(ok),
    .sd_we_i(sd_we), .sd_addr_i(sd_addr), .sd_data_i(sd_data), .sd_ok_o(sd_ok),
    .dbg_line_i(dbg_line), .dbg_words_o(dbg));

  shared_wmem #(.LINES(4), .WORD_W(32), .NREQ(3), .DELAY(0)) u1 (
    .clk(clk), .rst(rst), .req_i(req_z), .addr_i(addr_z), .data_i(data_z), .ok_o(ok_z),
    .sd_we_i(1'b0), .sd_addr_i(4'd0), .sd_data_i(32'd0), .sd_ok_o(sd_ok_z),
    .dbg_line_i(dbg_line_z), .dbg_words_o(dbg_z));

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(input int i, input logic [3:0] a, input logic [31:0] d);
    addr[4*i +: 4]  = a;
    data[32*i +: 32] = d;
  endtask

  function automatic logic [31:0] word(input logic [127:0] v, input int k);
    return v[32*k +: 32];
  endfunction

  task automatic wait_then_ok(input logic [2:0] exp, input string tag);
    for (int c = 0; c < D0; c++) begin
      #1 chk(32'(ok), 32'd0, tag);
      @(negedge clk);
    end
    #1 chk(32'(ok), 32'(exp), tag);
    @(negedge clk);
  endtask

  task automatic t_reset;
    #1 chk(32'(ok), 0, "R1 status idle");
    chk(32'(sd_ok), 0, "R1 side status idle");
    for (int l = 0; l < 4; l++) begin
      dbg_line = 2'(l);
      #1;
      for (int k = 0; k < 4; k++) chk(word(dbg, k), 0, "R1 zero word");
    end
  endtask

  task automatic t_latency;
    req = 3'b001; put(0, 4'd5, 32'hA5A5_0001);
    for (int c = 0; c < D0; c++) begin
      dbg_line = 2'(c);
      #1 chk(32'(ok), 0, "R5 wait cycle R9");
      @(negedge clk);
    end
    #1 chk(32'(ok), 32'b001, "R5 ok cycle");
    @(negedge clk);
    req = '0; dbg_line = 2'd1;
    #1 chk(word(dbg, 1), 32'hA5A5_0001, "R5 R2 written word");
    chk(word(dbg, 0), 0, "R2 neighbour word");
  endtask

  task automatic t_conflict;
    req = 3'b010; put(1, 4'd2, 32'hBBBB_0002);
    #1 chk(32'(ok), 0, "R3 claim wait");
    @(negedge clk);
    req = 3'b011; put(0, 4'd3, 32'hCCCC_0003);
    for (int c = 1; c < D0; c++) begin
      #1 chk(32'(ok), 0, "R3 other waits");
      @(negedge clk);
    end
    #1 chk(32'(ok), 32'b010, "R6 holder ok, other waits");
    @(negedge clk);
    req = 3'b001; dbg_line = 2'd0;
    #1 chk(word(dbg, 2), 32'hBBBB_0002, "R3 holder data");
    chk(word(dbg, 3), 0, "R3 waiter not written");
    wait_then_ok(3'b001, "R6 next claim full delay");
    req = '0;
    #1 chk(word(dbg, 3), 32'hCCCC_0003, "R6 second write");
  endtask

  task automatic t_priority;
    req = 3'b111;
    put(0, 4'd12, 32'h1111_000C); put(1, 4'd13, 32'h2222_000D); put(2, 4'd14, 32'h3333_000E);
    wait_then_ok(3'b001, "R4 memory stage first");
    req = 3'b110;
    wait_then_ok(3'b010, "R4 fetch second");
    req = 3'b100;
    wait_then_ok(3'b100, "R4 cache last");
    req = '0; dbg_line = 2'd3;
    #1 chk(word(dbg, 0), 32'h1111_000C, "R4 word0");
    chk(word(dbg, 1), 32'h2222_000D, "R4 word1");
    chk(word(dbg, 2), 32'h3333_000E, "R4 word2");
  endtask

  task automatic t_side;
    req = 3'b001; put(0, 4'd8, 32'hDDDD_0008);
    #1 chk(32'(ok), 0, "R8 holder wait");
    @(negedge clk);
    sd_we = 1'b1; sd_addr = 4'd9; sd_data = 32'hEEEE_0009;
    #1 chk(32'(sd_ok), 1, "R8 side ok");
    chk(32'(ok), 0, "R8 holder still waits");
    @(negedge clk);
    sd_we = 1'b0; dbg_line = 2'd2;
    #1 chk(word(dbg, 1), 32'hEEEE_0009, "R8 side committed");
    chk(word(dbg, 0), 0, "R8 holder not yet");
    chk(32'(ok), 0, "R8 holder wait kept");
    @(negedge clk);
    sd_we = 1'b1; sd_addr = 4'd8; sd_data = 32'hFFFF_0008;
    #1 chk(32'(ok), 32'b001, "R8 holder ok on time");
    @(negedge clk);
    sd_we = 1'b0; req = '0;
    #1 chk(word(dbg, 0), 32'hFFFF_0008, "R10 side wins");
  endtask

  task automatic t_zero;
    req_z = 3'b010; addr_z[7:4] = 4'd1; data_z[63:32] = 32'h6666_0001;
    #1 chk(32'(ok_z), 32'b010, "R7 immediate ok");
    @(negedge clk);
    req_z = 3'b101; addr_z[3:0] = 4'd0; data_z[31:0] = 32'h7777_0000;
    addr_z[11:8] = 4'd2; data_z[95:64] = 32'h8888_0002;
    #1 chk(32'(ok_z), 32'b001, "R7 R4 winner only");
    @(negedge clk);
    req_z = 3'b100;
    #1 chk(32'(ok_z), 32'b100, "R7 loser next cycle");
    @(negedge clk);
    req_z = '0; dbg_line_z = 2'd0;
    #1 chk(word(dbg_z, 0), 32'h7777_0000, "R7 word0");
    chk(word(dbg_z, 1), 32'h6666_0001, "R7 word1");
    chk(word(dbg_z, 2), 32'h8888_0002, "R7 word2");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    @(negedge clk); t_latency;
    @(negedge clk); t_conflict;
    @(negedge clk); t_priority;
    @(negedge clk); t_side;
    @(negedge clk); t_zero;
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule